// File: doc/BRIEF.md
# Boot Sector Top-Swap Remapper

This block sits on the processor's code-fetch address path and, when top-swap is in effect, steers fetches away from the primary boot block toward a backup copy kept elsewhere in flash. The backup is reached by flipping a single fetch address bit: bit 16, 17 or 18. Which one is flipped follows a boot-block-size field. The address path is purely combinational, so a fetch sees the remap in the same cycle.

Top-swap can be turned on in two ways. The first is a software control bit held in an always-powered domain, which survives system reset. The second is a hardware strap that is captured by a power-up strobe. A boot-lock bit, once set, freezes the control bit until the next system reset. A captured-high strap forces the swap without touching the stored control bit, and it also freezes that bit until a later power-up captures the strap low.

The effective swap is the OR of the captured strap and the control bit. Software sees all of this state through one register view.

Top module: `bootswap_remap`

## Requirements
- R1: After both resets, the register view `reg_rdata` reads 0, `swap_active` is 0 and `remap_addr` equals `fetch_addr`.
- R2: While `swap_active` is 1, exactly one bit of `remap_addr` differs from `fetch_addr`. The size field selects that bit: 00 selects bit 16, 01 selects bit 17, 10 selects bit 18, and the reserved 11 behaves like 00.
- R3: While `swap_active` is 0, `remap_addr` equals `fetch_addr` for every address and size setting.
- R4: A write with `reg_wr_en` high loads `reg_wdata[0]` into the control bit, visible in the cycle after the write, unless the write is blocked by R5 or R8. `swap_active` follows the control bit.
- R5: Writing 1 to `reg_wdata[1]` sets the lock bit. Writing 0 never clears it; only `sys_rst` does. While the lock bit is set, writes leave the control bit unchanged. A write that sets the lock still updates the control bit, because the old lock value governs that write.
- R6: `sys_rst` clears the lock bit and the size field but leaves the control bit and the captured strap unchanged. `aon_rst` clears the control bit and the captured strap.
- R7: When `strap_sample` is high, `strap_in` is captured. A captured 1 forces `swap_active` to 1 while the stored control bit keeps its own value.
- R8: While the captured strap is 1, writes leave the control bit unchanged. A later capture of 0 makes the control bit writable again.
- R9: Changes on `strap_in` while `strap_sample` is low have no effect on the captured strap.
- R10: The view `reg_rdata` holds the control bit in bit 0, the lock in bit 1, the size field in bits 3:2 and the captured strap in bit 4, with bits 7:5 reading 0. The size field is loaded from `reg_wdata[3:2]` on every write, whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aon_rst | input | 1 | Synchronous active-high reset of the always-powered domain |
| sys_rst | input | 1 | Synchronous active-high system reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register view |
| strap_in | input | 1 | Top-swap strap level, active high |
| strap_sample | input | 1 | Power-up capture strobe for the strap |
| fetch_addr | input | 32 | Fetch address from the processor |
| remap_addr | output | 32 | Address sent toward flash |
| swap_active | output | 1 | Effective top-swap state |

## Verification
Fetch addresses are applied with the selectable bits at both 0 and 1, under all four size codes. This shows that the correct bit flips in both directions and that the reserved code falls back to bit 16. Control-bit writes are tried in four states: unlocked, locked, in the same cycle as the lock write, and under a captured strap. Together these separate the lock blocking from the strap blocking. Reset and strap sequences alternate `sys_rst` and `aon_rst`, and the strap is toggled with the strobe both high and low. These sequences tell apart the domains that survive each reset and show that the strap is captured only on the strobe.

// File: rtl/bootswap_pkg.sv
package bootswap_pkg;

    typedef enum logic [1:0] {
        BS_SMALL = 2'b00,
        BS_MID   = 2'b01,
        BS_LARGE = 2'b10,
        BS_RSVD  = 2'b11
    } bsize_e;

    typedef struct packed {
        logic [2:0] pad;
        logic       strap;
        bsize_e     size;
        logic       lock;
        logic       swap;
    } ctl_view_t;

    typedef struct packed {
        logic   wr;
        logic   swap_bit;
        logic   lock_bit;
        bsize_e size;
    } wr_req_t;

    localparam int VIEW_W = $bits(ctl_view_t);

    function automatic logic [1:0] size_offset(bsize_e s);
        case (s)
            BS_MID:   return 2'd1;
            BS_LARGE: return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/bootswap_aon.sv
module bootswap_aon
    import bootswap_pkg::*;
(
    input  logic    clk,
    input  logic    aon_rst,
    input  wr_req_t req,
    input  logic    lock_q,
    input  logic    strap_in,
    input  logic    strap_sample,
    output logic    swap_q,
    output logic    strap_q
);
    logic wr_ok;

    assign wr_ok = req.wr && !lock_q && !strap_q;

    always_ff @(posedge clk) begin
        if (aon_rst) begin
            swap_q  <= 1'b0;
            strap_q <= 1'b0;
        end else begin
            if (strap_sample) strap_q <= strap_in;
            if (wr_ok)        swap_q  <= req.swap_bit;
        end
    end
endmodule

// File: rtl/bootswap_sys.sv
module bootswap_sys
    import bootswap_pkg::*;
(
    input  logic    clk,
    input  logic    sys_rst,
    input  wr_req_t req,
    output logic    lock_q,
    output bsize_e  size_q
);
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            lock_q <= 1'b0;
            size_q <= BS_SMALL;
        end else if (req.wr) begin
            lock_q <= lock_q | req.lock_bit;
            size_q <= req.size;
        end
    end
endmodule

// File: rtl/bootswap_flip.sv
module bootswap_flip
    import bootswap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BASE_BIT = 16
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              swap,
    input  bsize_e            size,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int SEL_W = $clog2(ADDR_W);

    logic [SEL_W-1:0] sel;

    assign sel = SEL_W'(BASE_BIT) + SEL_W'(size_offset(size));

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign addr_out[i] = addr_in[i] ^ (swap && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/bootswap_remap.sv
module bootswap_remap
    import bootswap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BASE_BIT = 16
) (
    input  logic              clk,
    input  logic              aon_rst,
    input  logic              sys_rst,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              strap_in,
    input  logic              strap_sample,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] remap_addr,
    output logic              swap_active
);
    wr_req_t   req;
    ctl_view_t view;
    logic      swap_q, strap_q, lock_q;
    bsize_e    size_q;

    assign req.wr       = reg_wr_en;
    assign req.swap_bit = reg_wdata[0];
    assign req.lock_bit = reg_wdata[1];
    assign req.size     = bsize_e'(reg_wdata[3:2]);

    bootswap_aon u_aon (
        .clk(clk), .aon_rst(aon_rst), .req(req), .lock_q(lock_q),
        .strap_in(strap_in), .strap_sample(strap_sample),
        .swap_q(swap_q), .strap_q(strap_q)
    );

    bootswap_sys u_sys (
        .clk(clk), .sys_rst(sys_rst), .req(req),
        .lock_q(lock_q), .size_q(size_q)
    );

    assign swap_active = swap_q | strap_q;

    bootswap_flip #(.ADDR_W(ADDR_W), .BASE_BIT(BASE_BIT)) u_flip (
        .addr_in(fetch_addr), .swap(swap_active), .size(size_q),
        .addr_out(remap_addr)
    );

    always_comb begin
        view       = '0;
        view.swap  = swap_q;
        view.lock  = lock_q;
        view.size  = size_q;
        view.strap = strap_q;
    end

    assign reg_rdata = view;
endmodule

module bootswap_remap_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              aon_rst,
    input logic              sys_rst,
    input logic              lock_q,
    input logic              strap_q,
    input logic              swap_q,
    input logic              strap_sample,
    input logic              swap_active,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] remap_addr
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (sys_rst)
        lock_q |=> lock_q); // R5
    AST_CTL_FROZEN: assert property (@(posedge clk) disable iff (aon_rst)
        (lock_q || strap_q) |=> $stable(swap_q)); // R8
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (aon_rst)
        !swap_active |-> remap_addr == fetch_addr); // R3
    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (aon_rst)
        swap_active |-> $countones(remap_addr ^ fetch_addr) == 1); // R2
    AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (aon_rst)
        !strap_sample |=> $stable(strap_q)); // R9
    AST_STRAP_FORCE: assert property (@(posedge clk) disable iff (aon_rst)
        strap_q |-> swap_active); // R7
endmodule

bind bootswap_remap bootswap_remap_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .aon_rst(aon_rst), .sys_rst(sys_rst), .lock_q(lock_q),
    .strap_q(strap_q), .swap_q(swap_q), .strap_sample(strap_sample),
    .swap_active(swap_active), .fetch_addr(fetch_addr), .remap_addr(remap_addr)
);

// File: tb/bootswap_remap_test.sv
module bootswap_remap_test;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        aon_rst = 1'b1, sys_rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        strap_in = 1'b0, strap_sample = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [31:0] remap_addr;
    logic        swap_active;

    int vectors = 0, miscompares = 0;

    // behavioural reference state
    bit m_swap, m_strap, m_lock;
    int m_size;

    always #(CLK_NS/2) clk = ~clk;

    bootswap_remap uut (
        .clk(clk), .aon_rst(aon_rst), .sys_rst(sys_rst),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .strap_in(strap_in), .strap_sample(strap_sample),
        .fetch_addr(fetch_addr), .remap_addr(remap_addr),
        .swap_active(swap_active)
    );

    function automatic logic [31:0] exp_addr(logic [31:0] a);
        int b;
        if (!(m_swap || m_strap)) return a;
        b = (m_size == 1) ? 17 : (m_size == 2) ? 18 : 16;
        return a ^ (32'h1 << b);
    endfunction

    task automatic compare(string tag);
        logic [7:0] ev;
        ev = {3'b000, m_strap, m_size[1:0], m_lock, m_swap};
        vectors++;
        if (reg_rdata !== ev || remap_addr !== exp_addr(fetch_addr)
            || swap_active !== (m_swap || m_strap)) begin
            miscompares++;
            $display("FAIL %s: rdata=%h addr=%h act=%b expected rdata=%h addr=%h act=%b",
                     tag, reg_rdata, remap_addr, swap_active, ev,
                     exp_addr(fetch_addr), m_swap || m_strap);
        end
    endtask

    // apply one cycle of stimulus, advance the model, compare at the falling edge
    task automatic step(string tag, bit ar, bit sr, bit we, logic [7:0] wd,
                        bit si, bit ss, logic [31:0] fa);
        aon_rst = ar; sys_rst = sr; reg_wr_en = we; reg_wdata = wd;
        strap_in = si; strap_sample = ss; fetch_addr = fa;
        @(posedge clk);
        if (ar) begin
            m_swap = 0; m_strap = 0;
        end else begin
            if (we && !m_lock && !m_strap) m_swap = wd[0];
            if (ss) m_strap = si;
        end
        if (sr) begin
            m_lock = 0; m_size = 0;
        end else if (we) begin
            m_lock = m_lock | wd[1];
            m_size = wd[3:2];
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic look(string tag, logic [31:0] fa);
        step(tag, 0, 0, 0, 8'h00, strap_in, 0, fa);
    endtask

    initial begin
        #(CLK_NS * 100000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        step("R1 reset", 1, 1, 0, 8'h00, 0, 0, 32'h0007_0000);
        look("R1 idle", 32'h0007_0000);
        // R3: no swap, all size codes, varied addresses
        for (int s = 0; s < 4; s++) begin
            step("R10 size write", 0, 0, 1, 8'(s << 2), 0, 0, 32'hFFFF_FFFF);
            look("R3 pass", 32'h0005_1234);
        end
        // R2/R4: swap on, every size, bits at 0 and 1
        for (int s = 0; s < 4; s++) begin
            step("R4 set swap", 0, 0, 1, 8'((s << 2) | 1), 0, 0, 32'h0000_0000);
            look("R2 flip zeros", 32'h0000_0000);
            look("R2 flip ones", 32'hFFFF_FFFF);
            look("R2 flip mix", 32'h0002_A5A5);
        end
        step("R4 clear swap", 0, 0, 1, 8'h04, 0, 0, 32'h0007_0000);
        // R5: lock with swap in same write, then blocked writes
        step("R5 lock+swap", 0, 0, 1, 8'h03, 0, 0, 32'h0001_0000);
        step("R5 blocked clear", 0, 0, 1, 8'h00, 0, 0, 32'h0001_0000);
        step("R5 lock holds", 0, 0, 1, 8'h08, 0, 0, 32'h0004_0000);
        // R6: system reset keeps control bit
        step("R6 sys_rst", 0, 1, 0, 8'h00, 0, 0, 32'h0001_0000);
        step("R4 clear after unlock", 0, 0, 1, 8'h00, 0, 0, 32'h0001_0000);
        step("R4 set again", 0, 0, 1, 8'h01, 0, 0, 32'h0001_0000);
        step("R6 aon_rst", 1, 0, 0, 8'h00, 0, 0, 32'h0001_0000);
        // R9: strap toggles without strobe
        step("R9 no strobe", 0, 0, 0, 8'h00, 1, 0, 32'h0000_0000);
        look("R9 still off", 32'h0003_0000);
        // R7/R8: strap captured high
        step("R7 capture", 0, 0, 0, 8'h00, 1, 1, 32'h0000_0000);
        step("R8 blocked set", 0, 0, 1, 8'h05, 1, 0, 32'h0000_0000);
        step("R9 drop no strobe", 0, 0, 0, 8'h00, 0, 0, 32'h0002_0000);
        step("R8 recapture low", 0, 0, 0, 8'h00, 0, 1, 32'h0002_0000);
        step("R8 writable", 0, 0, 1, 8'h09, 0, 0, 32'h0004_0000);
        step("R7 capture with ctl", 0, 0, 0, 8'h00, 1, 1, 32'h0004_0000);
        step("R6 aon clears strap", 1, 0, 0, 8'h00, 0, 0, 32'h0004_0000);
        look("R10 view", 32'h1234_5678);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule